// File: doc/BRIEF.md
# Multiplexed External Bus Port Mux

This block produces the pin drive and read-back logic for the four 8-bit I/O ports of a small 8-bit microcontroller. For every pin it gives a strong-low enable and a strong-high enable. A pin with neither enable set is left to its pull-up, or to the external net. The block holds the four port latches, and the core reads either a latch or the sampled pin levels through a single read path.

Ports 1, 2 and 3 are quasi-bidirectional. Each has an always-on weak pull-up outside this block, so the block only ever pulls low where a latch bit is 0. Port 0 has no pull-up and is open-drain in plain I/O use. During an external access, port 0 first carries the low address byte, then the write byte or the released read lines. Port 2 carries the high address byte, unless the data access uses an 8-bit address. The core tells the block that an access is under way, gives the address-latch strobe and the read strobe, and names the kind of access. The byte read back over the bus is held in a register.

Top module: `ext_bus_port_mux`

## Requirements
- R1: In the cycle after reset is released, all four latches read back 0xFF and no pin has either drive enable set.
- R2: With no access under way, port 0 never drives high (`drv_hi[7:0]` = 0), and it pulls low exactly on the bits where its latch holds 0 (`drv_lo[7:0]` = ~latch).
- R3: Ports 1 and 3 always pull low exactly where their latch bit is 0 and never drive high. Port 2 does the same when it is not carrying address. No pin ever has both enables set.
- R4: `rd_sel` chooses the port (0 to 3). The read returns that port's latch when `rd_from_latch` is 1, and that port's byte of `pin_in` (port n at bits 8n+7..8n) when it is 0.
- R5: During an access, before the address-latch strobe has been high and then low, port 0 drives `addr[7:0]` with both levels (`drv_hi` = value, `drv_lo` = ~value).
- R6: In the data phase of a data write, port 0 drives `bus_wdata` with both levels. The data phase is the part of the access after the address-latch strobe has been high and is now low. A data write is `acc_write`=1 with `acc_kind` not 00.
- R7: In the data phase of a read or a program fetch (`acc_kind`=00 ignores `acc_write`), port 0 sets no drive enable at all.
- R8: `bus_rdata` takes `pin_in[7:0]` on each clock edge where a read data phase has the read strobe high. At all other edges it keeps its value, so it holds the byte of the last strobe-high cycle.
- R9: During a program fetch (`acc_kind`=00) or a 16-bit-addressed data access (`acc_kind`=01), port 2 drives `addr[15:8]` with both levels.
- R10: During an 8-bit-addressed data access (`acc_kind`=1x), port 2 keeps its latch-driven quasi-bidirectional behaviour.
- R11: Every clock edge with an access under way loads 0xFF into the port 0 latch, and a software write to port 0 at that edge is dropped. After the access ends, the port 0 pins are released and the latch reads 0xFF.
- R12: Dropping `bus_active` ends an access. The next access starts in its address phase even when the address-latch strobe is low in its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_we | input | 1 | Latch write enable |
| lat_sel | input | 2 | Port whose latch is written |
| lat_wdata | input | 8 | Latch write value |
| rd_sel | input | 2 | Port to read back |
| rd_from_latch | input | 1 | 1: read the latch (read-modify-write), 0: read the pins |
| rd_data | output | 8 | Read-back byte |
| pin_in | input | 32 | Sampled pin levels, port n at bits 8n+7..8n |
| bus_active | input | 1 | External access under way |
| ale | input | 1 | Address-latch strobe |
| rd_strobe | input | 1 | Read strobe of the access |
| acc_kind | input | 2 | 00 program fetch, 01 data with 16-bit address, 1x data with 8-bit address |
| acc_write | input | 1 | Data access is a write |
| addr | input | 16 | Access address |
| bus_wdata | input | 8 | Byte to write over the bus |
| bus_rdata | output | 8 | Byte captured during a bus read |
| drv_lo | output | 32 | Per-pin strong-low enable |
| drv_hi | output | 32 | Per-pin strong-high enable |

## Verification
The assertions run on every cycle and check four things: no pin is ever driven both ways; port 0 never drives high outside an access; port 2 carries the high address in fetch and 16-bit data cycles; the port 0 latch reads all ones after every access cycle and after reset. They also check that the captured bus byte stays put unless a strobed read is in progress. The phase sequence needs the bench's scenarios. Those scenarios show address, then data or release, after the strobe falls, and a fresh access restarting in its address phase. They also cover the exact byte captured at the end of the read strobe, a software write to port 0 being lost during an access, and the pin-versus-latch read selection.

// File: rtl/port_mux_pkg.sv
`timescale 1ns/1ps
package port_mux_pkg;
    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 4;
    localparam int ADDR_W    = 16;
    localparam int SEL_W     = $clog2(NUM_PORTS);
    localparam int PINS_W    = PORT_W * NUM_PORTS;
    localparam int LOW_PORT  = 0;
    localparam int HIGH_PORT = 2;
    localparam logic [PORT_W-1:0] LATCH_INIT = '1;

    typedef enum logic [1:0] {
        ACC_FETCH       = 2'b00,
        ACC_DATA_WIDE   = 2'b01,
        ACC_DATA_NARROW = 2'b10,
        ACC_DATA_NARR2  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic [PORT_W-1:0] lo;
        logic [PORT_W-1:0] hi;
    } pin_drive_t;

    // Latch-driven pin: pull low on zeros, rely on pull-up or open drain for ones
    function automatic pin_drive_t latch_drive(input logic [PORT_W-1:0] lat);
        pin_drive_t d;
        d.lo = ~lat;
        d.hi = '0;
        return d;
    endfunction

    // Push-pull drive of a byte
    function automatic pin_drive_t strong_drive(input logic [PORT_W-1:0] v);
        pin_drive_t d;
        d.lo = ~v;
        d.hi = v;
        return d;
    endfunction

    function automatic pin_drive_t released();
        pin_drive_t d;
        d.lo = '0;
        d.hi = '0;
        return d;
    endfunction

    function automatic logic narrow_addr(input acc_kind_e k);
        return k[1];
    endfunction
endpackage

// File: rtl/port_latch_bank.sv
`timescale 1ns/1ps
module port_latch_bank
    import port_mux_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 we,
    input  logic [SEL_W-1:0]                     sel,
    input  logic [PORT_W-1:0]                    wdata,
    input  logic                                 low_bus_hold,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]     lat
);
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_lat
        always_ff @(posedge clk) begin
            if (rst) begin
                lat[g] <= LATCH_INIT;
            end else if ((g == LOW_PORT) && low_bus_hold) begin
                lat[g] <= LATCH_INIT;
            end else if (we && (sel == SEL_W'(g))) begin
                lat[g] <= wdata;
            end
        end
    end

    a_r1_latches_init: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lat == {NUM_PORTS{LATCH_INIT}}));

    a_r11_low_latch_ones: assert property (@(posedge clk) disable iff (rst)
        $past(low_bus_hold) |-> (lat[LOW_PORT] == LATCH_INIT));
endmodule

// File: rtl/low_port_bus.sv
`timescale 1ns/1ps
module low_port_bus
    import port_mux_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_active,
    input  logic               ale,
    input  logic               rd_strobe,
    input  acc_kind_e          kind,
    input  logic               acc_write,
    input  logic [PORT_W-1:0]  addr_lo,
    input  logic [PORT_W-1:0]  wdata,
    input  logic [PORT_W-1:0]  lat,
    input  logic [PORT_W-1:0]  pin,
    output pin_drive_t         drv,
    output logic [PORT_W-1:0]  rdata
);
    logic strobe_seen;
    logic data_phase;
    logic drives_data;
    logic capture;

    always_ff @(posedge clk) begin
        if (rst || !bus_active) begin
            strobe_seen <= 1'b0;
        end else if (ale) begin
            strobe_seen <= 1'b1;
        end
    end

    assign data_phase  = bus_active && strobe_seen && !ale;
    assign drives_data = acc_write && (kind != ACC_FETCH);
    assign capture     = data_phase && !drives_data && rd_strobe;

    always_comb begin
        if (!bus_active) begin
            drv = latch_drive(lat);
        end else if (!data_phase) begin
            drv = strong_drive(addr_lo);
        end else if (drives_data) begin
            drv = strong_drive(wdata);
        end else begin
            drv = released();
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= pin;
        end
    end

    a_r2_never_high_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_active |-> (drv.hi == '0));

    a_r8_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_active && rd_strobe) |-> $stable(rdata));
endmodule

// File: rtl/high_port_sel.sv
`timescale 1ns/1ps
module high_port_sel
    import port_mux_pkg::*;
(
    input  logic               bus_active,
    input  acc_kind_e          kind,
    input  logic [PORT_W-1:0]  addr_hi,
    input  logic [PORT_W-1:0]  lat,
    output pin_drive_t         drv
);
    always_comb begin
        if (bus_active && !narrow_addr(kind)) begin
            drv = strong_drive(addr_hi);
        end else begin
            drv = latch_drive(lat);
        end
    end
endmodule

// File: rtl/ext_bus_port_mux.sv
`timescale 1ns/1ps
module ext_bus_port_mux
    import port_mux_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lat_we,
    input  logic [1:0]           lat_sel,
    input  logic [7:0]           lat_wdata,
    input  logic [1:0]           rd_sel,
    input  logic                 rd_from_latch,
    output logic [7:0]           rd_data,
    input  logic [31:0]          pin_in,
    input  logic                 bus_active,
    input  logic                 ale,
    input  logic                 rd_strobe,
    input  logic [1:0]           acc_kind,
    input  logic                 acc_write,
    input  logic [15:0]          addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic [31:0]          drv_lo,
    output logic [31:0]          drv_hi
);
    logic [NUM_PORTS-1:0][PORT_W-1:0] lat;
    logic [NUM_PORTS-1:0][PORT_W-1:0] pin_arr;
    pin_drive_t                       pd [NUM_PORTS];
    acc_kind_e                        kind;

    assign kind    = acc_kind_e'(acc_kind);
    assign pin_arr = pin_in;

    port_latch_bank u_latches (
        .clk          (clk),
        .rst          (rst),
        .we           (lat_we),
        .sel          (lat_sel),
        .wdata        (lat_wdata),
        .low_bus_hold (bus_active),
        .lat          (lat)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        if (g == LOW_PORT) begin : g_low
            low_port_bus u_low (
                .clk        (clk),
                .rst        (rst),
                .bus_active (bus_active),
                .ale        (ale),
                .rd_strobe  (rd_strobe),
                .kind       (kind),
                .acc_write  (acc_write),
                .addr_lo    (addr[PORT_W-1:0]),
                .wdata      (bus_wdata),
                .lat        (lat[g]),
                .pin        (pin_arr[g]),
                .drv        (pd[g]),
                .rdata      (bus_rdata)
            );
        end else if (g == HIGH_PORT) begin : g_high
            high_port_sel u_high (
                .bus_active (bus_active),
                .kind       (kind),
                .addr_hi    (addr[ADDR_W-1 -: PORT_W]),
                .lat        (lat[g]),
                .drv        (pd[g])
            );
        end else begin : g_quasi
            assign pd[g] = latch_drive(lat[g]);
        end
        assign drv_lo[g*PORT_W +: PORT_W] = pd[g].lo;
        assign drv_hi[g*PORT_W +: PORT_W] = pd[g].hi;
    end

    assign rd_data = rd_from_latch ? lat[rd_sel] : pin_arr[rd_sel];

    a_r3_no_fight: assert property (@(posedge clk) disable iff (rst)
        (drv_lo & drv_hi) == '0);

    a_r9_high_addr: assert property (@(posedge clk) disable iff (rst)
        (bus_active && !acc_kind[1]) |->
            (drv_hi[HIGH_PORT*PORT_W +: PORT_W] == addr[ADDR_W-1 -: PORT_W]));
endmodule

// File: tb/tb_ext_bus_port_mux.sv
`timescale 1ns/1ps
module tb_ext_bus_port_mux;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lat_we = 1'b0;
    logic [1:0]  lat_sel = '0;
    logic [7:0]  lat_wdata = '0;
    logic [1:0]  rd_sel = '0;
    logic        rd_from_latch = 1'b0;
    logic [7:0]  rd_data;
    logic [31:0] pin_in = '0;
    logic        bus_active = 1'b0;
    logic        ale = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        acc_write = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] drv_lo;
    logic [31:0] drv_hi;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam int K_LO = 0, K_HI = 1, K_RD = 2, K_BUS = 3;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    ext_bus_port_mux dut (.*);

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_v(input int k, input logic [31:0] v, input string tag);
        item_t it;
        it.kind = k;
        it.exp  = v;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_LO:    act = drv_lo;
                    K_HI:    act = drv_hi;
                    K_RD:    act = {24'h0, rd_data};
                    default: act = {24'h0, bus_rdata};
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic wr_latch(input logic [1:0] p, input logic [7:0] v);
        tick();
        lat_we = 1'b1; lat_sel = p; lat_wdata = v;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state
        tick();
        expect_v(K_LO, 32'h0, "R1");
        expect_v(K_HI, 32'h0, "R1");
        for (int p = 0; p < 4; p++) begin
            tick();
            rd_from_latch = 1'b1; rd_sel = 2'(p);
            expect_v(K_RD, 32'hFF, "R1");
        end
        // R2: port 0 open drain
        wr_latch(2'd0, 8'h5A);
        tick(); lat_we = 1'b0;
        expect_v(K_LO, 32'h000000A5, "R2");
        expect_v(K_HI, 32'h0, "R2");
        // R3: quasi ports
        wr_latch(2'd1, 8'h0F);
        wr_latch(2'd3, 8'h81);
        wr_latch(2'd2, 8'h3C);
        tick(); lat_we = 1'b0;
        expect_v(K_LO, 32'h7EC3F0A5, "R3");
        expect_v(K_HI, 32'h0, "R3");
        // R4: pin versus latch read
        tick(); pin_in = 32'h11223344; rd_sel = 2'd2; rd_from_latch = 1'b0;
        expect_v(K_RD, 32'h22, "R4");
        tick(); rd_from_latch = 1'b1;
        expect_v(K_RD, 32'h3C, "R4");
        tick(); rd_sel = 2'd0; rd_from_latch = 1'b0;
        expect_v(K_RD, 32'h44, "R4");
        // R5/R9: fetch, address phase
        tick(); bus_active = 1'b1; ale = 1'b1; acc_kind = 2'b00; acc_write = 1'b0; addr = 16'hBEEF;
        expect_v(K_HI, 32'h00BE00EF, "R5 R9");
        expect_v(K_LO, 32'h7E41F010, "R5 R9");
        // R7: read data phase releases port 0; R11: write to port 0 during access
        tick(); ale = 1'b0; rd_strobe = 1'b1; pin_in = 32'h11223399;
        lat_we = 1'b1; lat_sel = 2'd0; lat_wdata = 8'h00;
        expect_v(K_HI, 32'h00BE0000, "R7");
        expect_v(K_LO, 32'h7E41F000, "R7");
        // R8: captured byte from last strobe-high cycle
        tick(); lat_we = 1'b0; rd_strobe = 1'b0; pin_in = 32'h11223377;
        expect_v(K_BUS, 32'h99, "R8");
        tick();
        expect_v(K_BUS, 32'h99, "R8");
        // R11: after access, port 0 released, latch ones
        tick(); bus_active = 1'b0; rd_sel = 2'd0; rd_from_latch = 1'b1;
        expect_v(K_LO, 32'h7EC3F000, "R11");
        expect_v(K_HI, 32'h0, "R11");
        expect_v(K_RD, 32'hFF, "R11");
        // R10/R5: 8-bit addressed write
        tick(); bus_active = 1'b1; ale = 1'b1; acc_kind = 2'b10; acc_write = 1'b1;
        addr = 16'h12C4; bus_wdata = 8'h6B;
        expect_v(K_HI, 32'h000000C4, "R10 R5");
        expect_v(K_LO, 32'h7EC3F03B, "R10 R5");
        // R6: write data phase
        tick(); ale = 1'b0;
        expect_v(K_HI, 32'h0000006B, "R6");
        expect_v(K_LO, 32'h7EC3F094, "R6");
        tick(); bus_active = 1'b0;
        expect_v(K_BUS, 32'h99, "R8");
        // R12: new access without strobe starts in address phase
        tick(); bus_active = 1'b1; ale = 1'b0; acc_kind = 2'b01; acc_write = 1'b1; addr = 16'h4321;
        expect_v(K_HI, 32'h00430021, "R12 R9");
        expect_v(K_LO, 32'h7EBCF0DE, "R12 R9");
        tick(); bus_active = 1'b0;
        tick();
        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule